// File: doc/BRIEF.md
# Grouped-Format Instruction Decoder

This block accepts one 8-bit instruction word at a time and splits it into three fields. The two most significant bits give an operand-count class. The next two bits name a register. The low four bits are the operation code. The instruction word never carries operands itself. The class alone decides where the operands come from: the accumulator, the named register, or a reserved memory-operand slot.

The memory-operand slot sits at the address the stack pointer is given when the stack is set up. The block receives that address on a dedicated input and latches it when an instruction is accepted. For the address class, the block reads two consecutive bytes from that slot through a simple synchronous read port. It assembles them into a 16-bit effective address, either direct or with the index register added.

A one-cycle completion strobe marks the cycle in which every output needed by the decoded class is valid. The block then holds its outputs until the next instruction is accepted. Execution, branching and instruction buffering belong to neighbouring blocks.

Top module: `grp_decoder`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `memRd` are 0, and `group`, `regSel`, `opcode`, `opA`, `opB` and `effAddr` are all zero.
- R2: An instruction is accepted on a rising edge where `start` is 1 and `busy` is 0. From the next cycle, `group` shows bits 7:6, `regSel` shows bits 5:4 and `opcode` shows bits 3:0 of the accepted word.
- R3: Class 0 (bits 7:6 = 0) performs no memory read. `done` rises in the first cycle after acceptance, and `opA`, `opB` and `effAddr` are 0.
- R4: Class 1 performs no memory read. `done` rises in the first cycle after acceptance, `opA` equals the accumulator input at acceptance, and `opB` and `effAddr` are 0.
- R5: Class 2 sets `opA` to the low byte of the register chosen by bits 5:4 at acceptance. The choices are 0 = accumulator, 1 = index, 2 = stack pointer and 3 = position. The class performs exactly one read at the latched slot address, sets `opB` to the byte returned, and raises `done` in the third cycle after acceptance. `effAddr` is 0.
- R6: Class 3 reads the slot address and then that address plus one, wrapping modulo 2^16. `effAddr` is {byte at slot+1, byte at slot}. `done` rises in the fourth cycle after acceptance, and `opA` and `opB` are 0.
- R7: When `idxMode` is 1 at acceptance, the class 3 `effAddr` is the fetched address plus the index input at acceptance, modulo 2^16. When `idxMode` is 0, `effAddr` is the fetched address unchanged.
- R8: `memRd` is raised only for classes 2 and 3. `memData` is taken in the cycle after the one in which `memRd` was high.
- R9: `start` is ignored while `busy` is 1, including the cycle in which `done` is high. Changes to the instruction, mode, slot address or register inputs after acceptance do not alter the results.
- R10: `done` is high for exactly one cycle. `busy` is 1 from the cycle after acceptance through the `done` cycle, and 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to accept `instr` |
| instr | input | 8 | Instruction word |
| idxMode | input | 1 | 1 = indexed, 0 = direct addressing for class 3 |
| stackBase | input | 16 | Initial stack pointer value, which is the memory-operand slot address |
| accVal | input | 8 | Accumulator contents |
| idxVal | input | 16 | Index register contents |
| spVal | input | 8 | Low byte of the stack pointer |
| posVal | input | 8 | Position register contents |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | 16 | Memory read address |
| memData | input | 8 | Read data, valid the cycle after `memRd` |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle completion strobe |
| group | output | 2 | Decoded operand class |
| regSel | output | 2 | Decoded register select |
| opcode | output | 4 | Decoded operation code |
| opA | output | 8 | Register operand |
| opB | output | 8 | Memory operand |
| effAddr | output | 16 | Effective address |

## Verification
The completion strobe and a fresh `start` request can fall in the same cycle. The bench provokes this on every instruction. It raises `start` with a different instruction word and scrambled side inputs from the first busy cycle onward, so the request is still present on the edge that leaves the `done` cycle. It then drops the request and checks that the held outputs and the idle state match the first instruction alone. Latency, read addresses and operand values are computed in the bench from the field rules, using a memory model whose contents follow from each address.

// File: rtl/grp_decoder_pkg.sv
package grp_decoder_pkg;

  typedef enum logic [1:0] {
    CLS_CTRL = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_TWO  = 2'd2,
    CLS_ADDR = 2'd3
  } opClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDLO,
    ST_GETLO,
    ST_GETHI,
    ST_FIN
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic rdLo;
    logic rdHi;
    logic takeLo;
    logic takeHi;
  } dpStrobe_t;

endpackage

// File: rtl/grp_decoder_ctrl.sv
module grp_decoder_ctrl
  import grp_decoder_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [1:0] newClass,
  input  logic [1:0] heldClass,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  seqState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        nextState = newClass[1] ? ST_RDLO : ST_FIN;
      end
      ST_RDLO: begin
        strobe.rdLo = 1'b1;
        nextState   = ST_GETLO;
      end
      ST_GETLO: begin
        strobe.takeLo = 1'b1;
        if (heldClass == CLS_ADDR) begin
          strobe.rdHi = 1'b1;
          nextState   = ST_GETHI;
        end else begin
          nextState = ST_FIN;
        end
      end
      ST_GETHI: begin
        strobe.takeHi = 1'b1;
        nextState     = ST_FIN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

endmodule

// File: rtl/grp_decoder_dpath.sv
module grp_decoder_dpath
  import grp_decoder_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int OPC_W  = DATA_W - 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] instr,
  input  logic              idxMode,
  input  logic [ADDR_W-1:0] stackBase,
  input  logic [DATA_W-1:0] accVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [DATA_W-1:0] spVal,
  input  logic [DATA_W-1:0] posVal,
  input  logic [DATA_W-1:0] memData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        group,
  output logic [1:0]        regSel,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [ADDR_W-1:0] effAddr
);

  logic [ADDR_W-1:0] baseQ, idxQ;
  logic [DATA_W-1:0] loQ, regPick;
  logic              idxModeQ;
  logic [1:0]        newClass;

  assign newClass = instr[DATA_W-1 -: 2];

  always_comb begin
    case (instr[DATA_W-3 -: 2])
      2'd0:    regPick = accVal;
      2'd1:    regPick = idxVal[DATA_W-1:0];
      2'd2:    regPick = spVal;
      default: regPick = posVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      group <= '0; regSel <= '0; opcode <= '0;
      opA <= '0; opB <= '0; effAddr <= '0;
      baseQ <= '0; idxQ <= '0; loQ <= '0; idxModeQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        group    <= newClass;
        regSel   <= instr[DATA_W-3 -: 2];
        opcode   <= instr[OPC_W-1:0];
        baseQ    <= stackBase;
        idxQ     <= idxVal;
        idxModeQ <= idxMode;
        opB      <= '0;
        effAddr  <= '0;
        case (newClass)
          CLS_ONE: opA <= accVal;
          CLS_TWO: opA <= regPick;
          default: opA <= '0;
        endcase
      end
      if (strobe.takeLo) begin
        if (group == CLS_TWO) opB <= memData;
        else                  loQ <= memData;
      end
      if (strobe.takeHi)
        effAddr <= {memData, loQ} + (idxModeQ ? idxQ : '0);
    end
  end

  assign memRd   = strobe.rdLo | strobe.rdHi;
  assign memAddr = strobe.rdHi ? baseQ + 1'b1 : baseQ;

  p_mem_only_wide_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> group[1]);

  p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHi |-> $past(strobe.rdLo));

endmodule

// File: rtl/grp_decoder.sv
module grp_decoder
  import grp_decoder_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int OPC_W  = DATA_W - 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  input  logic              idxMode,
  input  logic [ADDR_W-1:0] stackBase,
  input  logic [DATA_W-1:0] accVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [DATA_W-1:0] spVal,
  input  logic [DATA_W-1:0] posVal,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        group,
  output logic [1:0]        regSel,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [ADDR_W-1:0] effAddr
);

  dpStrobe_t strobe;

  grp_decoder_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .newClass(instr[DATA_W-1 -: 2]), .heldClass(group),
    .strobe(strobe), .busy(busy), .done(done)
  );

  grp_decoder_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instr(instr),
    .idxMode(idxMode), .stackBase(stackBase), .accVal(accVal),
    .idxVal(idxVal), .spVal(spVal), .posVal(posVal), .memData(memData),
    .memRd(memRd), .memAddr(memAddr), .group(group), .regSel(regSel),
    .opcode(opcode), .opA(opA), .opB(opB), .effAddr(effAddr)
  );

  p_fields_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(group) && $stable(regSel) && $stable(opcode)));

endmodule

// File: tb/grp_decoder_tb_top.sv
module grp_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  instr = '0;
  logic        idxMode = 1'b0;
  logic [15:0] stackBase = '0;
  logic [7:0]  accVal = '0;
  logic [15:0] idxVal = '0;
  logic [7:0]  spVal = '0;
  logic [7:0]  posVal = '0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        busy, done;
  logic [1:0]  group, regSel;
  logic [3:0]  opcode;
  logic [7:0]  opA, opB;
  logic [15:0] effAddr;

  int errs = 0;
  int checks = 0;
  logic [7:0] salt = 8'h3C;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  grp_decoder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .idxMode(idxMode),
    .stackBase(stackBase), .accVal(accVal), .idxVal(idxVal), .spVal(spVal),
    .posVal(posVal), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done), .group(group), .regSel(regSel),
    .opcode(opcode), .opA(opA), .opB(opB), .effAddr(effAddr)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5 ^ salt;
  endfunction

  always @(posedge clk) if (memRd) memData <= memf(memAddr);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOne(input logic [7:0] ins, input bit ind, input logic [15:0] base,
                        input logic [7:0] acc, input logic [15:0] idx,
                        input logic [7:0] sp, input logic [7:0] pos);
    logic [1:0]  g;
    logic [7:0]  eA, eB, sel;
    logic [15:0] eE, rdA0, rdA1;
    int lat, nRd, cyc;
    bit seen;
    string lt;
    g = ins[7:6];
    case (ins[5:4])
      2'd0: sel = acc;
      2'd1: sel = idx[7:0];
      2'd2: sel = sp;
      default: sel = pos;
    endcase
    eA = (g == 2'd1) ? acc : (g == 2'd2) ? sel : 8'h00;
    eB = (g == 2'd2) ? memf(base) : 8'h00;
    eE = (g == 2'd3) ? ({memf(base + 16'd1), memf(base)} + (ind ? idx : 16'd0)) : 16'd0;
    lat = (g == 2'd2) ? 3 : (g == 2'd3) ? 4 : 1;
    lt = (g == 2'd0) ? "R3" : (g == 2'd1) ? "R4" : (g == 2'd2) ? "R5" : "R6";

    @(negedge clk);
    instr = ins; idxMode = ind; stackBase = base; accVal = acc;
    idxVal = idx; spVal = sp; posVal = pos; start = 1'b1;
    @(posedge clk);
    cyc = 0; nRd = 0; seen = 1'b0; rdA0 = '0; rdA1 = '0;
    while (!seen && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (memRd) begin
        if (nRd == 0) rdA0 = memAddr;
        if (nRd == 1) rdA1 = memAddr;
        nRd++;
      end
      if (done) seen = 1'b1;
      if (cyc == 1) begin
        check(busy, "R10 busy after accept", busy, 1);
        // R9: new request and scrambled inputs while busy
        instr = ~ins; idxMode = ~ind; stackBase = $urandom; accVal = $urandom;
        idxVal = $urandom; spVal = $urandom; posVal = $urandom; start = 1'b1;
      end
    end
    check(seen && cyc == lat, {lt, " done latency"}, cyc, lat);
    check(group == ins[7:6], "R2 group field", group, ins[7:6]);
    check(regSel == ins[5:4], "R2 regSel field", regSel, ins[5:4]);
    check(opcode == ins[3:0], "R2 opcode field", opcode, ins[3:0]);
    check(opA == eA, {lt, " opA"}, opA, eA);
    check(opB == eB, {lt, " opB / R8 data"}, opB, eB);
    check(effAddr == eE, ind ? "R7 indexed effAddr" : {lt, " effAddr"}, effAddr, eE);
    check(nRd == ((g == 2'd2) ? 1 : (g == 2'd3) ? 2 : 0), "R8 read count", nRd, 0);
    if (g[1]) check(rdA0 == base, "R5/R6 first read address", rdA0, base);
    if (g == 2'd3) check(rdA1 == base + 16'd1, "R6 second read address", rdA1, base + 16'd1);
    @(negedge clk);
    start = 1'b0;
    check(!done, "R10 done single cycle", done, 0);
    check(!busy, "R9 start ignored at done cycle", busy, 0);
    check(group == ins[7:6] && opA == eA && opB == eB && effAddr == eE,
          "R9 outputs held", {group, opA, opB}, {ins[7:6], eA, eB});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_1F2E));
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd, "R1 reset control", {busy, done, memRd}, 0);
    check(group == 0 && regSel == 0 && opcode == 0 && opA == 0 && opB == 0 && effAddr == 0,
          "R1 reset data", {opA, opB, effAddr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memRd && effAddr == 0, "R1 after reset", {busy, done}, 0);

    // directed corners
    runOne(8'h05, 1'b0, 16'h1000, 8'h11, 16'h2233, 8'h44, 8'h55);
    runOne(8'h4A, 1'b0, 16'h1000, 8'hC3, 16'h2233, 8'h44, 8'h55);
    for (int r = 0; r < 4; r++)
      runOne({2'b10, r[1:0], 4'h7}, 1'b0, 16'h0200, 8'h11, 16'hAB22, 8'h33, 8'h44);
    runOne(8'hC1, 1'b0, 16'hFFFF, 8'h00, 16'h0000, 8'h00, 8'h00);
    runOne(8'hF2, 1'b1, 16'h0400, 8'h00, 16'hFFFF, 8'h00, 8'h00);
    runOne(8'hC9, 1'b1, 16'hFFFF, 8'h00, 16'h8001, 8'h00, 8'h00);

    for (int i = 0; i < 300; i++) begin
      salt = $urandom;
      runOne($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule